// File: doc/BRIEF.md
# Multiplexed Asynchronous Memory Bus Sequencer

This block runs one access at a time to an external asynchronous memory whose address and data share one set of pins. A host presents an address, write data, a direction flag and a one-cycle start. The block then drives a chip-select strobe, an address-valid strobe, a read strobe, a write strobe and the shared bus. It finishes with a one-cycle done pulse, which carries the captured read data on reads.

Each access runs through three phases in a fixed order. The first is address setup, while the address-valid strobe is low. The second is address hold. The third is the data phase. The length of each phase comes from a configuration input. A write's data phase lasts one cycle longer than a read's, so the data stays on the bus for one cycle after the write strobe rises. A programmable idle gap separates consecutive accesses. When enabled, a wait input with a selectable active level stretches the data phase. Configuration inputs must stay stable while an access is in flight.

Top module: `mbus_async_seq`

## Requirements
- R1: After reset, all four strobes (`mem_ce_n`, `mem_adv_n`, `mem_oe_n`, `mem_we_n`) are high and `busy`, `rsp_done` and `mem_ad_oe` are low.
- R2: A start accepted in cycle t drives `mem_ce_n` low from cycle t+1. Only in the first max(setup,1) cycles of that window is `mem_adv_n` low. `mem_ce_n` stays low for max(setup,1) + hold + data-length cycles, where a setup value of 0 is treated as 1.
- R3: A read's data phase lasts max(`cfg_datast`,1) cycles. `mem_oe_n` is low for exactly that phase and rises in the same cycle as `mem_ce_n`.
- R4: Read data is the value on `mem_ad_in` in the last cycle with `mem_oe_n` low. It appears on `rsp_rdata` together with a one-cycle `rsp_done` in the cycle that `mem_ce_n` rises.
- R5: A write's data phase lasts `cfg_datast`+1 cycles. `mem_we_n` is low for its first `cfg_datast` cycles and high in its last cycle.
- R6: During setup and hold, `mem_ad_out` carries the request address with `mem_ad_oe` high. During a write data phase it carries the write data with `mem_ad_oe` high. While `mem_oe_n` is low, `mem_ad_oe` is low.
- R7: With `cfg_busturn` = N ≥ 1 and a start held high, `mem_ce_n` stays high for exactly N cycles between two accesses.
- R8: A start raised while `busy` is high is ignored. It produces no extra access, no extra done and no change to the address in flight.
- R9: A write request while `cfg_write_en` is 0 returns `rsp_done` with `rsp_err` high on the next cycle, and `mem_ce_n` never goes low.
- R10: With `cfg_wait_en` = 1, `mem_wait` is active when it equals `cfg_wait_pol` (1 = active high). It passes through a two-flop synchronizer. While the synchronized wait is active, the data-phase count is frozen. Releasing the pin after m data cycles gives a read data phase of m + 1 + `cfg_datast` cycles.
- R11: With `cfg_wait_en` = 0, or with `mem_wait` at its inactive level, the data phase is never stretched.
- R12: With `cfg_wide` = 0 (8-bit data), the upper byte of write data driven in the data phase is 0, and the upper byte of `rsp_rdata` is 0. With `cfg_wide` = 1, all 16 bits pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addset | input | 4 | Address-setup length in cycles (0 acts as 1) |
| cfg_addhld | input | 4 | Address-hold length in cycles (0 skips the phase) |
| cfg_datast | input | 8 | Data-phase base length |
| cfg_busturn | input | 4 | Idle cycles between accesses |
| cfg_wait_en | input | 1 | Enable wait stretching |
| cfg_wait_pol | input | 1 | Wait active level (1 = high) |
| cfg_write_en | input | 1 | Permit write accesses |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit data |
| req_start | input | 1 | Start pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access or gap in progress; start not accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write refused (with done) |
| rsp_rdata | output | 16 | Captured read data |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ad_out | output | 16 | Shared address/data bus, outgoing value |
| mem_ad_oe | output | 1 | Bus driver enable |
| mem_ad_in | input | 16 | Shared bus, incoming value |
| mem_wait | input | 1 | Asynchronous wait from the memory |

## Verification
The assertions check on every cycle these relations between strobes: address-valid only inside chip select, read and write strobes never low together, and the bus never driven while the read strobe is low. They also check that a refused write leaves chip select high, that a start during the data phase never restarts the setup phase, and that the phase count holds while wait is active. Phase lengths, turnaround gaps, the exact read-capture cycle, the stretch produced by the synchronizer latency, and 8-bit masking can only be shown by the bench. It does this by counting strobe cycles and comparing the done results against a scoreboard of expected read data and error flags.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int SET_W = 4;
    localparam int DST_W = 8;
    localparam int CNT_W = DST_W + 1;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_HOLD  = 3'd2,
        PH_DATA  = 3'd3,
        PH_TURN  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [SET_W-1:0] addset;
        logic [SET_W-1:0] addhld;
        logic [SET_W-1:0] busturn;
        logic [DST_W-1:0] datast;
    } timing_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    // writes get one extra cycle so data outlives the write strobe
    function automatic logic [CNT_W-1:0] data_len(input timing_t t, input logic wr);
        logic [CNT_W-1:0] base;
        base = CNT_W'(t.datast);
        return wr ? base + CNT_W'(1) : at_least_one(base);
    endfunction

endpackage

// File: rtl/mbus_wait_sync.sv
module mbus_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/mbus_phase_timer.sv
module mbus_phase_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         freeze,
    output logic [W-1:0] remaining,
    output logic         expire
);
    always_ff @(posedge clk) begin
        if (rst)                            remaining <= '0;
        else if (load)                      remaining <= load_val;
        else if (!freeze && remaining != '0) remaining <= remaining - W'(1);
    end

    assign expire = (remaining == W'(1)) && !freeze;

    // R10: the count does not move while the data phase is held off
    a_r10_hold_when_frozen: assert property (@(posedge clk) disable iff (rst)
        (freeze && !load) |=> (remaining == $past(remaining)));
endmodule

// File: rtl/mbus_async_seq.sv
module mbus_async_seq
    import mbus_pkg::*;
#(
    parameter int BUS_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] cfg_addset,
    input  logic [SET_W-1:0] cfg_addhld,
    input  logic [DST_W-1:0] cfg_datast,
    input  logic [SET_W-1:0] cfg_busturn,
    input  logic             cfg_wait_en,
    input  logic             cfg_wait_pol,
    input  logic             cfg_write_en,
    input  logic             cfg_wide,
    input  logic             req_start,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             busy,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             mem_ce_n,
    output logic             mem_adv_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [BUS_W-1:0] mem_ad_out,
    output logic             mem_ad_oe,
    input  logic [BUS_W-1:0] mem_ad_in,
    input  logic             mem_wait
);
    localparam int HALF = BUS_W / 2;

    phase_e            ph, ph_n;
    logic              wr_q;
    logic [BUS_W-1:0]  addr_q, wdata_q;
    timing_t           tcfg;
    logic              wait_s, wait_act, freeze;
    logic              tm_load, tm_expire;
    logic [CNT_W-1:0]  tm_val, tm_left;
    logic              turn_last, accept, reject, launch, data_end;

    assign tcfg = '{addset: cfg_addset, addhld: cfg_addhld,
                    busturn: cfg_busturn, datast: cfg_datast};

    function automatic logic [BUS_W-1:0] lane_mask(input logic [BUS_W-1:0] v, input logic wide);
        return wide ? v : {{(BUS_W-HALF){1'b0}}, v[HALF-1:0]};
    endfunction

    mbus_wait_sync #(.STAGES(SYNC_STAGES)) u_wsync (
        .clk(clk), .rst(rst), .din(mem_wait), .dout(wait_s)
    );

    assign wait_act = cfg_wait_en && (wait_s == cfg_wait_pol);
    assign freeze   = (ph == PH_DATA) && wait_act;

    mbus_phase_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tm_load), .load_val(tm_val),
        .freeze(freeze), .remaining(tm_left), .expire(tm_expire)
    );

    assign turn_last = (ph == PH_TURN) && tm_expire;
    assign busy      = (ph != PH_IDLE) && !turn_last;
    assign accept    = req_start && !busy;
    assign reject    = accept && req_write && !cfg_write_en;
    assign launch    = accept && !reject;
    assign data_end  = (ph == PH_DATA) && tm_expire;

    always_comb begin
        ph_n    = ph;
        tm_load = 1'b0;
        tm_val  = '0;
        unique case (ph)
            PH_IDLE, PH_TURN: begin
                if (launch) begin
                    ph_n    = PH_SETUP;
                    tm_load = 1'b1;
                    tm_val  = at_least_one(CNT_W'(tcfg.addset));
                end else if (turn_last) begin
                    ph_n = PH_IDLE;
                end
            end
            PH_SETUP: begin
                if (tm_expire) begin
                    tm_load = 1'b1;
                    if (tcfg.addhld != '0) begin
                        ph_n   = PH_HOLD;
                        tm_val = CNT_W'(tcfg.addhld);
                    end else begin
                        ph_n   = PH_DATA;
                        tm_val = data_len(tcfg, wr_q);
                    end
                end
            end
            PH_HOLD: begin
                if (tm_expire) begin
                    ph_n    = PH_DATA;
                    tm_load = 1'b1;
                    tm_val  = data_len(tcfg, wr_q);
                end
            end
            PH_DATA: begin
                if (tm_expire) begin
                    if (tcfg.busturn != '0) begin
                        ph_n    = PH_TURN;
                        tm_load = 1'b1;
                        tm_val  = CNT_W'(tcfg.busturn);
                    end else begin
                        ph_n = PH_IDLE;
                    end
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph        <= PH_IDLE;
            wr_q      <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            ph       <= ph_n;
            rsp_done <= data_end || reject;
            rsp_err  <= reject;
            if (launch) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (data_end && !wr_q)
                rsp_rdata <= lane_mask(mem_ad_in, cfg_wide);
        end
    end

    // strobes and bus, all decoded from registered state
    always_comb begin
        mem_ce_n   = !((ph == PH_SETUP) || (ph == PH_HOLD) || (ph == PH_DATA));
        mem_adv_n  = !(ph == PH_SETUP);
        mem_oe_n   = !((ph == PH_DATA) && !wr_q);
        mem_we_n   = !((ph == PH_DATA) && wr_q && (tm_left > CNT_W'(1)));
        mem_ad_oe  = 1'b0;
        mem_ad_out = '0;
        if ((ph == PH_SETUP) || (ph == PH_HOLD)) begin
            mem_ad_oe  = 1'b1;
            mem_ad_out = addr_q;
        end else if ((ph == PH_DATA) && wr_q) begin
            mem_ad_oe  = 1'b1;
            mem_ad_out = lane_mask(wdata_q, cfg_wide);
        end
    end

    a_r2_adv_within_ce: assert property (@(posedge clk) disable iff (rst)
        !mem_adv_n |-> !mem_ce_n);

    a_r6_no_drive_while_oe: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_ad_oe);

    a_r5_we_oe_exclusive: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    a_r5_data_outlives_we: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_ad_oe));

    a_r3_oe_ends_with_ce: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_oe_n) |-> mem_ce_n);

    a_r9_reject_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (mem_ce_n && rsp_done));

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        ((ph == PH_DATA) && req_start) |=> (ph != PH_SETUP));

    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !rsp_err) |=> !rsp_done);
endmodule

// File: tb/mbus_async_seq_tb.sv
module mbus_async_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cfg_addset = 4'd1, cfg_addhld = 4'd0, cfg_busturn = 4'd0;
    logic [7:0]  cfg_datast = 8'd1;
    logic        cfg_wait_en = 1'b0, cfg_wait_pol = 1'b1, cfg_write_en = 1'b1, cfg_wide = 1'b1;
    logic        req_start = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic        busy, rsp_done, rsp_err;
    logic [15:0] rsp_rdata, mem_ad_out, mem_ad_in;
    logic        mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_ad_oe;
    logic        mem_wait = 1'b0;

    int total = 0;
    int bad   = 0;

    typedef struct packed { logic err; logic rd; logic [15:0] data; } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    mbus_async_seq u_dut (
        .clk(clk), .rst(rst),
        .cfg_addset(cfg_addset), .cfg_addhld(cfg_addhld), .cfg_datast(cfg_datast),
        .cfg_busturn(cfg_busturn), .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
        .cfg_write_en(cfg_write_en), .cfg_wide(cfg_wide),
        .req_start(req_start), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in), .mem_wait(mem_wait)
    );

    // memory model: latch address at end of address-valid, answer reads with a pattern
    logic [15:0] lat_addr = '0;
    always @(posedge clk) if (!mem_adv_n) lat_addr <= mem_ad_out;
    assign mem_ad_in = !mem_oe_n ? (lat_addr ^ 16'h5A3C) : 16'h0000;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [15:0] a);
        logic [15:0] v;
        v = a ^ 16'h5A3C;
        return cfg_wide ? v : (v & 16'h00FF);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R8 unexpected done", 32'(rsp_done), 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_err == e.err, e.err ? "R9 err flag" : "R4 err flag", 32'(rsp_err), 32'(e.err));
                if (e.rd)
                    check(rsp_rdata == e.data, cfg_wide ? "R4 read data" : "R12 read data",
                          32'(rsp_rdata), 32'(e.data));
            end
        end
    end

    int m_adv, m_ce, m_oe, m_we, m_cont;
    logic [15:0] m_addr, m_wdata;
    bit m_wseen, m_addr_bad;

    task automatic access(input logic wr, input logic [15:0] a, input logic [15:0] d,
                          input int rel, input bit poke);
        bit seen, poked, prev_we;
        exp_t e;
        m_adv = 0; m_ce = 0; m_oe = 0; m_we = 0; m_cont = 0;
        m_wseen = 0; m_addr_bad = 0; m_addr = '0; m_wdata = '0;
        seen = 0; poked = 0; prev_we = 1;
        e.err  = wr && !cfg_write_en;
        e.rd   = !wr;
        e.data = exp_rd(a);
        sb.push_back(e);
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (!mem_adv_n) begin
                m_adv++;
                m_addr = mem_ad_out;
                if (!mem_ad_oe || mem_ad_out != a) m_addr_bad = 1;
            end
            if (!mem_ce_n) begin m_ce++; seen = 1; end
            if (!mem_oe_n) begin m_oe++; if (mem_ad_oe) m_cont++; end
            if (!mem_we_n) m_we++;
            if (!prev_we && mem_we_n && !mem_ce_n && mem_ad_oe) begin
                m_wseen = 1; m_wdata = mem_ad_out;
            end
            prev_we = mem_we_n;
            if (poke && m_ce == 2 && !poked) begin
                req_start = 1'b1; req_addr = ~a; poked = 1;
            end else begin
                req_start = 1'b0; req_addr = a;
            end
            if (rel > 0 && m_oe == rel) mem_wait = ~cfg_wait_pol;
            if (seen && mem_ce_n) break;
            if (!seen && i >= 8) break;
            @(negedge clk);
        end
        req_start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n, "R1 strobes idle", 32'({mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n}), 32'hF);
        check(!busy && !rsp_done && !mem_ad_oe, "R1 status idle", 32'({busy, rsp_done, mem_ad_oe}), 32'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // read: setup 2, hold 1, data 3
        cfg_addset = 4'd2; cfg_addhld = 4'd1; cfg_datast = 8'd3;
        access(1'b0, 16'h1234, 16'h0, 0, 0);
        check(m_adv == 2, "R2 adv length", 32'(m_adv), 32'd2);
        check(m_ce == 6, "R2 ce length", 32'(m_ce), 32'd6);
        check(m_oe == 3, "R3 oe length", 32'(m_oe), 32'd3);
        check(!m_addr_bad, "R6 address on bus", 32'(m_addr), 32'h1234);
        check(m_cont == 0, "R6 bus released during oe", 32'(m_cont), 32'd0);
        repeat (3) @(negedge clk);

        // write: setup 1, hold 0, data 2 (+1)
        cfg_addset = 4'd1; cfg_addhld = 4'd0; cfg_datast = 8'd2;
        access(1'b1, 16'hC0DE, 16'hBEEF, 0, 0);
        check(m_ce == 4, "R5 write ce length", 32'(m_ce), 32'd4);
        check(m_we == 2, "R5 we length", 32'(m_we), 32'd2);
        check(m_oe == 0, "R5 no oe on write", 32'(m_oe), 32'd0);
        check(m_wseen && m_wdata == 16'hBEEF, "R6 write data held after we", 32'(m_wdata), 32'hBEEF);
        check(!m_addr_bad && m_adv == 1, "R6 write address", 32'(m_addr), 32'hC0DE);
        repeat (3) @(negedge clk);

        // zero setup acts as one, zero data on read acts as one
        cfg_addset = 4'd0; cfg_addhld = 4'd2; cfg_datast = 8'd0;
        access(1'b0, 16'h0F0F, 16'h0, 0, 0);
        check(m_adv == 1, "R2 zero setup", 32'(m_adv), 32'd1);
        check(m_ce == 4, "R2 ce with zero setup", 32'(m_ce), 32'd4);
        check(m_oe == 1, "R3 zero data read", 32'(m_oe), 32'd1);
        repeat (3) @(negedge clk);

        // write with longer hold
        cfg_addset = 4'd3; cfg_addhld = 4'd2; cfg_datast = 8'd1;
        access(1'b1, 16'h4242, 16'h1357, 0, 0);
        check(m_ce == 7, "R5 write ce length 2", 32'(m_ce), 32'd7);
        check(m_we == 1, "R5 we length 2", 32'(m_we), 32'd1);
        check(m_wdata == 16'h1357, "R6 write data 2", 32'(m_wdata), 32'h1357);
        repeat (3) @(negedge clk);

        // start pulses during an access are ignored
        cfg_addset = 4'd2; cfg_addhld = 4'd0; cfg_datast = 8'd2;
        access(1'b0, 16'h2468, 16'h0, 0, 1);
        check(m_ce == 4 && !m_addr_bad, "R8 access unchanged by start", 32'(m_ce), 32'd4);
        begin
            int extra;
            extra = 0;
            repeat (12) begin @(negedge clk); if (!mem_ce_n) extra++; end
            check(extra == 0, "R8 no second access", 32'(extra), 32'd0);
        end

        // turnaround gap of 3 with start held
        cfg_addset = 4'd1; cfg_addhld = 4'd0; cfg_datast = 8'd1; cfg_busturn = 4'd3;
        access(1'b0, 16'h1111, 16'h0, 0, 0);
        begin
            exp_t e;
            int gap;
            e.err = 1'b0; e.rd = 1'b1; e.data = exp_rd(16'h2222);
            sb.push_back(e);
            req_write = 1'b0; req_addr = 16'h2222; req_start = 1'b1;
            gap = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (mem_ce_n) gap++; else break;
            end
            req_start = 1'b0;
            check(gap == 3, "R7 turnaround gap", 32'(gap), 32'd3);
        end
        repeat (12) @(negedge clk);
        cfg_busturn = 4'd0;

        // refused write
        cfg_write_en = 1'b0;
        access(1'b1, 16'h7777, 16'h8888, 0, 0);
        check(m_ce == 0 && m_we == 0, "R9 no bus activity", 32'(m_ce), 32'd0);
        cfg_write_en = 1'b1;
        repeat (3) @(negedge clk);

        // wait stretching, active high, released after 3 data cycles
        cfg_addset = 4'd1; cfg_addhld = 4'd0; cfg_datast = 8'd2;
        cfg_wait_en = 1'b1; cfg_wait_pol = 1'b1; mem_wait = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b0, 16'h3C3C, 16'h0, 3, 0);
        check(m_oe == 6, "R10 stretched oe", 32'(m_oe), 32'd6);
        check(m_ce == 7, "R10 stretched ce", 32'(m_ce), 32'd7);
        repeat (3) @(negedge clk);

        // active-low polarity with pin high: no stretch
        cfg_wait_pol = 1'b0; mem_wait = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b0, 16'h5555, 16'h0, 0, 0);
        check(m_oe == 2, "R10 inactive level no stretch", 32'(m_oe), 32'd2);
        repeat (3) @(negedge clk);

        // wait disabled, pin at what would be the active level
        cfg_wait_en = 1'b0; cfg_wait_pol = 1'b1; mem_wait = 1'b1;
        repeat (4) @(negedge clk);
        access(1'b0, 16'h6666, 16'h0, 0, 0);
        check(m_oe == 2, "R11 wait disabled no stretch", 32'(m_oe), 32'd2);
        mem_wait = 1'b0;
        repeat (3) @(negedge clk);

        // 8-bit data width
        cfg_wide = 1'b0;
        access(1'b0, 16'h1234, 16'h0, 0, 0);
        repeat (3) @(negedge clk);
        access(1'b1, 16'h9ABC, 16'hBEEF, 0, 0);
        check(m_wdata == 16'h00EF, "R12 narrow write data", 32'(m_wdata), 32'h00EF);
        cfg_wide = 1'b1;
        repeat (5) @(negedge clk);

        check(sb.size() == 0, "R8 every request answered once", 32'(sb.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        check(1'b0, "watchdog", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule